// File: doc/BRIEF.md
# Programmable Performance Event Counter Slot

This block is one slot of a hardware performance monitor. A 64-bit selector register picks four raw event counts out of a vector that carries one small count per event source every cycle. The four picks pass through a two-level tree of operators. Each operator is set per slot to OR, AND, XOR or ADD. The tree's output is added to a 64-bit counter on the next clock edge.

Counting stops when a global inhibit input is high. It also stops when the selector's inhibit bit for the current privilege mode is set. A sticky flag in the selector records a carry out of the counter, and only a hardware increment can raise it. Software writes the selector and the counter through two write ports and reads both back at all times.

Top module: `perf_slot`

## Requirements
- R1: After reset the selector and the counter both read zero, so every operator field holds OR (code 0).
- R2: Selector layout: event indices 0..3 at bits 9:0, 19:10, 29:20 and 39:30. Operators 0..2 at bits 44:40, 49:45 and 54:50. Inhibit bits for machine, supervisor, user, virtual-supervisor and virtual-user modes at bits 62, 61, 60, 59 and 58. Overflow flag at bit 63. Bits 57:55 always read zero, and all writable fields read back what was written.
- R3: A selector write that carries an operator code other than 0, 1, 2 or 4 leaves that operator field unchanged. The other fields of the same write still take effect.
- R4: Operator codes are OR=0, AND=1, XOR=2 and ADD=4. Operator 0 combines events 0 and 1, operator 1 combines events 2 and 3, and operator 2 combines the two intermediate results.
- R5: An event index equal to or above the number of event sources contributes a zero count.
- R6: Event counts presented in one cycle are added in full to the counter at that cycle's clock edge, and the counter keeps the low 64 bits of the sum. A combined value of zero leaves the counter unchanged.
- R7: Counting is inhibited when the global inhibit input is 1, or when the inhibit bit of the current mode is set. Mode is chosen as follows: privilege 3 selects machine (bit 62) whatever the virtualization input is. Privilege 1 with virtualization 0 selects bit 61, and with virtualization 1 selects bit 59. Privilege 0 with virtualization 0 selects bit 60, and with virtualization 1 selects bit 58.
- R8: The overflow flag is set when a hardware increment carries out of bit 63 of the counter.
- R9: Once set, the overflow flag stays set. A selector write with bit 63 at 0 clears it, and a write with bit 63 at 1 keeps its current value. No software write ever sets it.
- R10: A selector write in the same cycle as an overflowing increment takes priority: the flag takes the written result and the hardware set is dropped.
- R11: A counter write takes priority over a same-cycle increment. The written value is loaded, and that increment cannot set the overflow flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_cnt | input | NUM_EVT*EVT_W | Per-cycle event counts, source i at bits i*EVT_W upward |
| priv | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| virt | input | 1 | Current virtualization state |
| inhibit_all | input | 1 | Global counting inhibit |
| sel_we | input | 1 | Selector write enable |
| sel_wdata | input | 64 | Selector write data |
| cnt_we | input | 1 | Counter write enable |
| cnt_wdata | input | 64 | Counter write data |
| sel_rdata | output | 64 | Selector read-back |
| cnt_rdata | output | 64 | Counter read-back |

## Verification
The assertions watch properties on every cycle that need no knowledge of the event stream. They check that stored operator codes stay legal, that the overflow flag is sticky, that no software write raises the flag, that a counter write lands exactly, and that the counter holds while inhibited or fed a zero value. Only the bench scenarios can show the arithmetic: the operator tree results for each code mix, out-of-range index handling, the per-mode inhibit decode, and wrap-around. They also show the timing of the flag at the exact cycle of a carry against same-cycle writes.

// File: rtl/perf_slot.sv
module perf_slot #(
  parameter int NUM_EVT = 8,
  parameter int EVT_W   = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_EVT*EVT_W-1:0] evt_cnt,
  input  logic [1:0]               priv,
  input  logic                     virt,
  input  logic                     inhibit_all,
  input  logic                     sel_we,
  input  logic [63:0]              sel_wdata,
  input  logic                     cnt_we,
  input  logic [63:0]              cnt_wdata,
  output logic [63:0]              sel_rdata,
  output logic [63:0]              cnt_rdata
);
  localparam int IDX_W = 10;
  localparam int OP_W  = 5;
  localparam int CMB_W = EVT_W + 2;
  localparam logic [OP_W-1:0] OP_OR = 5'd0, OP_AND = 5'd1, OP_XOR = 5'd2, OP_ADD = 5'd4;

  logic [4*IDX_W-1:0] idx_q;
  logic [3*OP_W-1:0]  ops_q;
  logic [4:0]         inh_q;
  logic               of_q;
  logic [63:0]        cnt_q;

  logic [EVT_W-1:0] pick [4];
  logic [CMB_W-1:0] lo, hi, cmb;
  logic             mode_inh, count_en, hw_of;
  logic [64:0]      sum;
  logic             unused_wbits;

  assign unused_wbits = &{1'b0, sel_wdata[57:55]};

  function automatic logic op_legal(input logic [OP_W-1:0] c);
    return (c == OP_OR) || (c == OP_AND) || (c == OP_XOR) || (c == OP_ADD);
  endfunction

  function automatic logic [CMB_W-1:0] apply_op(input logic [OP_W-1:0] c,
                                                input logic [CMB_W-1:0] a,
                                                input logic [CMB_W-1:0] b);
    case (c)
      OP_OR:   return a | b;
      OP_AND:  return a & b;
      OP_XOR:  return a ^ b;
      OP_ADD:  return a + b;
      default: return '0;
    endcase
  endfunction

  function automatic logic [EVT_W-1:0] sel_evt(input logic [IDX_W-1:0] idx,
                                               input logic [NUM_EVT*EVT_W-1:0] v);
    logic [EVT_W-1:0] r;
    r = '0;
    for (int i = 0; i < NUM_EVT; i++)
      if (idx == IDX_W'(i)) r = v[i*EVT_W +: EVT_W];
    return r;
  endfunction

  for (genvar k = 0; k < 4; k++) begin : g_pick
    assign pick[k] = sel_evt(idx_q[k*IDX_W +: IDX_W], evt_cnt);
  end

  assign lo  = apply_op(ops_q[0 +: OP_W], CMB_W'(pick[0]), CMB_W'(pick[1]));
  assign hi  = apply_op(ops_q[OP_W +: OP_W], CMB_W'(pick[2]), CMB_W'(pick[3]));
  assign cmb = apply_op(ops_q[2*OP_W +: OP_W], lo, hi);

  always_comb begin
    case ({virt, priv})
      3'b011, 3'b111: mode_inh = inh_q[4];
      3'b001:         mode_inh = inh_q[3];
      3'b000:         mode_inh = inh_q[2];
      3'b101:         mode_inh = inh_q[1];
      3'b100:         mode_inh = inh_q[0];
      default:        mode_inh = 1'b0;
    endcase
  end

  assign count_en = !inhibit_all && !mode_inh && (cmb != '0);
  assign sum      = {1'b0, cnt_q} + 65'(cmb);
  assign hw_of    = count_en && !cnt_we && sum[64];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
      ops_q <= '0;
      inh_q <= '0;
      of_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      if (cnt_we)        cnt_q <= cnt_wdata;
      else if (count_en) cnt_q <= sum[63:0];
      if (sel_we) begin
        idx_q <= sel_wdata[4*IDX_W-1:0];
        for (int k = 0; k < 3; k++)
          if (op_legal(sel_wdata[4*IDX_W + k*OP_W +: OP_W]))
            ops_q[k*OP_W +: OP_W] <= sel_wdata[4*IDX_W + k*OP_W +: OP_W];
        inh_q <= sel_wdata[62:58];
        of_q  <= of_q & sel_wdata[63];
      end else if (hw_of) begin
        of_q <= 1'b1;
      end
    end
  end

  assign sel_rdata = {of_q, inh_q, 3'b000, ops_q, idx_q};
  assign cnt_rdata = cnt_q;

  AST_OP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    op_legal(ops_q[0 +: OP_W]) && op_legal(ops_q[OP_W +: OP_W]) && op_legal(ops_q[2*OP_W +: OP_W])); // R3
  AST_OF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    of_q && !sel_we |=> of_q); // R9
  AST_OF_NO_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_we || cnt_we) && !of_q |=> !of_q); // R9
  AST_CNT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> cnt_q == $past(cnt_wdata)); // R11
  AST_INHIBIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit_all && !cnt_we |=> $stable(cnt_q)); // R7
  AST_ZERO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmb == '0) && !cnt_we |=> $stable(cnt_q)); // R6
endmodule

// File: tb/sim_perf_slot.sv
`timescale 1ns/1ps
module sim_perf_slot;
  localparam int NUM_EVT = 8;
  localparam int EVT_W   = 6;
  localparam int NROW    = 14;
  localparam logic [47:0] EVT = {6'd7, 6'd0, 6'd1, 6'd63, 6'd10, 6'd12, 6'd3, 6'd5};

  function automatic logic [63:0] mk(input int e0, input int e1, input int e2, input int e3,
                                     input int o0, input int o1, input int o2, input int inh);
    logic [63:0] r;
    r = '0;
    r[9:0]   = 10'(e0);
    r[19:10] = 10'(e1);
    r[29:20] = 10'(e2);
    r[39:30] = 10'(e3);
    r[44:40] = 5'(o0);
    r[49:45] = 5'(o1);
    r[54:50] = 5'(o2);
    r[62:58] = 5'(inh);
    return r;
  endfunction

  localparam logic [63:0] T_SEL [NROW] = '{
    mk(0,1,2,3, 0,0,0, 0),  mk(0,1,2,3, 4,4,4, 0),  mk(0,1,2,3, 1,2,4, 0),
    mk(0,1,2,3, 2,1,2, 0),  mk(4,4,4,4, 4,4,4, 0),  mk(6,6,6,6, 0,0,0, 0),
    mk(0,900,700,200, 4,4,4, 0), mk(0,1,2,3, 4,4,4, 16), mk(0,1,2,3, 4,4,4, 8),
    mk(0,1,2,3, 4,4,4, 8),  mk(0,1,2,3, 4,4,4, 1),  mk(0,1,2,3, 4,4,4, 4),
    mk(0,1,2,3, 4,4,4, 2),  mk(0,1,2,3, 4,4,4, 0)};
  localparam logic [1:0]  T_PRIV [NROW] = '{3,3,3,3,3,3,3,3,3,1,0,0,1,3};
  localparam logic        T_VIRT [NROW] = '{0,0,0,0,0,0,0,0,0,0,1,1,1,0};
  localparam logic        T_GINH [NROW] = '{0,0,0,0,0,0,0,0,0,0,0,0,0,1};
  localparam logic [63:0] T_EXP  [NROW] = '{15,30,7,14,252,0,5,0,30,0,0,30,0,0};
  localparam string       T_REQ  [NROW] = '{"R4","R4","R4","R4","R6","R6","R5",
                                            "R7","R7","R7","R7","R7","R7","R7"};

  logic clk = 0, rst_n = 0;
  logic [NUM_EVT*EVT_W-1:0] evt_cnt = '0;
  logic [1:0] priv = 2'd3;
  logic virt = 0, inhibit_all = 0, sel_we = 0, cnt_we = 0;
  logic [63:0] sel_wdata = '0, cnt_wdata = '0;
  logic [63:0] sel_rdata, cnt_rdata;
  int total = 0, bad = 0;
  logic done = 0;

  always #2 clk = ~clk;

  perf_slot #(.NUM_EVT(NUM_EVT), .EVT_W(EVT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .evt_cnt(evt_cnt), .priv(priv), .virt(virt),
    .inhibit_all(inhibit_all), .sel_we(sel_we), .sel_wdata(sel_wdata),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .sel_rdata(sel_rdata), .cnt_rdata(cnt_rdata));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic sw, input logic [63:0] sv, input logic cw,
                      input logic [63:0] cv, input logic [47:0] ev);
    sel_we = sw; sel_wdata = sv; cnt_we = cw; cnt_wdata = cv; evt_cnt = ev;
    @(negedge clk);
    sel_we = 0; cnt_we = 0; evt_cnt = '0;
  endtask

  initial begin
    logic [63:0] s;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1", sel_rdata, 64'd0);
    chk("R1", cnt_rdata, 64'd0);

    for (int i = 0; i < NROW; i++) begin
      step(1, T_SEL[i], 1, 64'd0, '0);
      chk("R2", sel_rdata, T_SEL[i]);
      priv = T_PRIV[i]; virt = T_VIRT[i]; inhibit_all = T_GINH[i];
      step(0, '0, 0, '0, EVT);
      chk(T_REQ[i], cnt_rdata, T_EXP[i]);
      priv = 2'd3; virt = 0; inhibit_all = 0;
    end

    step(1, mk(1,2,3,4, 4,4,4, 0), 0, '0, '0);
    step(1, mk(5,6,7,8, 0,7,2, 0), 0, '0, '0);
    chk("R3", sel_rdata, mk(5,6,7,8, 0,4,2, 0));
    step(1, '1, 0, '0, '0);
    chk("R2", sel_rdata, mk(1023,1023,1023,1023, 0,4,2, 31));

    s = mk(0,1,2,3, 4,4,4, 0);
    step(1, s, 1, 64'hFFFF_FFFF_FFFF_FFFA, '0);
    step(0, '0, 0, '0, EVT);
    chk("R6", cnt_rdata, 64'd24);
    chk("R8", {63'd0, sel_rdata[63]}, 64'd1);
    step(0, '0, 0, '0, '0);
    chk("R9", {63'd0, sel_rdata[63]}, 64'd1);
    step(1, s | (64'd1 << 63), 0, '0, '0);
    chk("R9", {63'd0, sel_rdata[63]}, 64'd1);
    step(1, s, 0, '0, '0);
    chk("R9", {63'd0, sel_rdata[63]}, 64'd0);
    step(1, s | (64'd1 << 63), 0, '0, '0);
    chk("R9", {63'd0, sel_rdata[63]}, 64'd0);

    step(0, '0, 1, 64'hFFFF_FFFF_FFFF_FFFA, '0);
    step(0, '0, 1, 64'd100, EVT);
    chk("R11", cnt_rdata, 64'd100);
    chk("R11", {63'd0, sel_rdata[63]}, 64'd0);

    step(0, '0, 1, 64'hFFFF_FFFF_FFFF_FFFA, '0);
    step(1, s, 0, '0, EVT);
    chk("R10", cnt_rdata, 64'd24);
    chk("R10", {63'd0, sel_rdata[63]}, 64'd0);

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule